// File: doc/BRIEF.md
# Cascadable Binary Decoder with Dual Active-Low Selects

The block turns a binary address into a one-of-N active-low line. Its building piece is a 4-bit slice with sixteen outputs and two active-low select inputs. The slice drives a line only when both selects are held low, so the selects serve as gating inputs for cascading.

The top module is a 5-bit, 32-line decoder built from two slices. The address bits above the slice width are decoded into the first select of each slice, so that exactly one slice is enabled at a time. One shared active-low enable drives the second select of every slice. With the default width, address bit 4 low enables the slice that covers codes 0 to 15, and address bit 4 high enables the slice that covers codes 16 to 31.

The path is purely combinational and has no clock. There is no data stream at its edge, so it has no valid/ready handshake: the address and the enable are plain control pins, and the outputs follow them directly.

Top module: `dec_wide`

## Requirements
- R1: In a slice with both selects low, the output whose index equals the 4-bit address is 0 and the other fifteen outputs are 1.
- R2: In a slice with either select high (or both), all sixteen outputs are 1 whatever the address.
- R3: In the top module, with `cs_n_i` low, output `dec_n_o[n]` is 0 exactly when `addr_i` equals n, and every other output is 1.
- R4: In the top module, with `cs_n_i` low and `addr_i` from 0 to 15, outputs 16 to 31 are all 1 because the high slice is disabled.
- R5: In the top module, with `cs_n_i` low and `addr_i` from 16 to 31, outputs 0 to 15 are all 1 because the low slice is disabled.
- R6: In the top module, with `cs_n_i` high, all 32 outputs are 1 for every address.
- R7: At most one of the 32 top outputs is 0 at any time, and exactly one slice is enabled whenever `cs_n_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 5 | Binary address to decode; the top bit picks the slice |
| cs_n_i | input | 1 | Active-low enable shared by all slices |
| dec_n_o | output | 32 | Active-low decoded lines; bit n is 0 when `addr_i` equals n and the block is enabled |

## Verification
The slice is driven through every address under all four select combinations. This separates correct gating by either select from the one-hot decode itself. The wide decoder is swept over all 32 addresses with the enable both low and high, which shows whether the top address bit steers to the right slice and whether the idle half stays at 1. Random address and enable pairs from a fixed seed then mix these cases in arbitrary order. Directed checks at codes 15 and 16 target the boundary between the two slices.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int SLICE_W = 4;
  localparam int SLICE_N = 1 << SLICE_W;
  localparam int WIDE_W  = 5;
endpackage

// File: rtl/dec_slice.sv
module dec_slice #(
  parameter int SEL_W = dec_pkg::SLICE_W,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             cs_a_n_i,
  input  logic             cs_b_n_i,
  output logic [LINES-1:0] line_n_o
);
  logic enabled;
  assign enabled = ~cs_a_n_i & ~cs_b_n_i;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      line_n_o[i] = ~(enabled && (sel_i == SEL_W'(i)));
    end
  end
endmodule

// File: rtl/dec_steer.sv
module dec_steer #(
  parameter int UP_W = 1,
  localparam int NS = 1 << UP_W
) (
  input  logic [UP_W-1:0] upper_i,
  input  logic            en_n_i,
  output logic [NS-1:0]   cs_a_n_o,
  output logic [NS-1:0]   cs_b_n_o
);
  always_comb begin
    for (int k = 0; k < NS; k++) begin
      cs_a_n_o[k] = (upper_i != UP_W'(k));
      cs_b_n_o[k] = en_n_i;
    end
  end
endmodule

// File: rtl/dec_wide.sv
module dec_wide #(
  parameter int ADDR_W = dec_pkg::WIDE_W,
  localparam int SW    = dec_pkg::SLICE_W,
  localparam int SN    = 1 << SW,
  localparam int UP_W  = ADDR_W - SW,
  localparam int NSL   = 1 << UP_W,
  localparam int OUT_N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  output logic [OUT_N-1:0]  dec_n_o
);
  logic [NSL-1:0] cs_a_n;
  logic [NSL-1:0] cs_b_n;

  dec_steer #(.UP_W(UP_W)) u_steer (
    .upper_i  (addr_i[ADDR_W-1:SW]),
    .en_n_i   (cs_n_i),
    .cs_a_n_o (cs_a_n),
    .cs_b_n_o (cs_b_n)
  );

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    dec_slice #(.SEL_W(SW)) u_slice (
      .sel_i    (addr_i[SW-1:0]),
      .cs_a_n_i (cs_a_n[g]),
      .cs_b_n_i (cs_b_n[g]),
      .line_n_o (dec_n_o[g*SN +: SN])
    );
  end
endmodule

// File: rtl/dec_wide_chk.sv
module dec_wide_chk #(
  parameter int ADDR_W = 5,
  parameter int NSL = 2,
  localparam int OUT_N = 1 << ADDR_W
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic              cs_n_i,
  input logic [OUT_N-1:0]  dec_n_o,
  input logic [NSL-1:0]    cs_a_n,
  input logic [NSL-1:0]    cs_b_n
);
  always_comb begin
    if (!$isunknown({addr_i, cs_n_i, dec_n_o, cs_a_n, cs_b_n})) begin
      a_r7_one_low: assert ($onehot0(~dec_n_o))
        else $error("more than one decoded line low");
      a_r7_one_slice: assert ($countones(~(cs_a_n | cs_b_n)) == (cs_n_i ? 0 : 1))
        else $error("slice enable count wrong");
      if (cs_n_i) begin
        a_r6_all_idle: assert (&dec_n_o) else $error("line low while disabled");
      end else begin
        a_r3_addr_line: assert (dec_n_o[addr_i] == 1'b0)
          else $error("addressed line not low");
      end
    end
  end
endmodule

bind dec_wide dec_wide_chk #(.ADDR_W(ADDR_W), .NSL(NSL)) u_chk (
  .addr_i  (addr_i),
  .cs_n_i  (cs_n_i),
  .dec_n_o (dec_n_o),
  .cs_a_n  (cs_a_n),
  .cs_b_n  (cs_b_n)
);

// File: tb/test_dec_wide.sv
module test_dec_wide;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]  addr;
  logic        cs_n;
  logic [31:0] dec_n;
  logic [3:0]  s_sel;
  logic        s_a_n, s_b_n;
  logic [15:0] s_out;

  int checks = 0;
  int errors = 0;

  dec_wide i_dec_wide (.addr_i(addr), .cs_n_i(cs_n), .dec_n_o(dec_n));
  dec_slice i_slice (.sel_i(s_sel), .cs_a_n_i(s_a_n), .cs_b_n_i(s_b_n), .line_n_o(s_out));

  function automatic logic [31:0] exp_wide(input logic [4:0] a, input logic c);
    if (c) return '1;
    return ~(32'd1 << a);
  endfunction

  function automatic logic [15:0] exp_slice(input logic [3:0] a, input logic ca, input logic cb);
    if (ca || cb) return '1;
    return ~(16'd1 << a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive_wide(input logic [4:0] a, input logic c);
    @(posedge clk);
    addr = a; cs_n = c;
    @(negedge clk);
    if (c) chk("R6", dec_n, '1);
    else begin
      chk("R3", dec_n, exp_wide(a, c));
      if (a < 16) chk("R4", {16'd0, dec_n[31:16]}, 32'h0000ffff);
      else        chk("R5", {16'd0, dec_n[15:0]},  32'h0000ffff);
    end
    chk("R7", 32'($countones(~dec_n) <= 1), 32'd1);
  endtask

  task automatic drive_slice(input logic [3:0] a, input logic ca, input logic cb);
    @(posedge clk);
    s_sel = a; s_a_n = ca; s_b_n = cb;
    @(negedge clk);
    if (ca || cb) chk("R2", {16'd0, s_out}, {16'd0, exp_slice(a, ca, cb)});
    else          chk("R1", {16'd0, s_out}, {16'd0, exp_slice(a, ca, cb)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    addr = '0; cs_n = 1'b1; s_sel = '0; s_a_n = 1'b1; s_b_n = 1'b1;
    unused_seed = $urandom(32'd1234);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", dec_n, '1);
    chk("R2", {16'd0, s_out}, 32'h0000ffff);
    // R1 R2: slice, every address under each select pair
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++)
        drive_slice(4'(a), m[0], m[1]);
    // R3..R7: wide decoder exhaustive
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 32; a++)
        drive_wide(5'(a), c[0]);
    // boundary between slices, R4 and R5
    drive_wide(5'd15, 1'b0);
    drive_wide(5'd16, 1'b0);
    drive_wide(5'd31, 1'b0);
    drive_wide(5'd0, 1'b0);
    // random mix
    for (int i = 0; i < 300; i++)
      drive_wide(5'($urandom), ($urandom % 4) == 0);
    for (int i = 0; i < 100; i++)
      drive_slice(4'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule